// File: doc/BRIEF.md
# ADC conversion mode sequencer

This block is the digital sequencer that sits between a serial configuration interface and the modulator of a delta-sigma converter with four selectable resolutions. It keeps a small configuration register (resolution code, gain code, mode bit), restores that register to its defaults on any reset, and holds off all conversions until an analog settling interval has passed after power comes up. After that it starts conversions on its own, back to back in continuous mode or one at a time in one-shot mode. In one-shot mode it parks in a low-power standby state after each conversion until a start command arrives.

Each raw modulator result is taken as a two's complement number of the resolution that was active when the conversion began. It is sign-extended to a common 18-bit word, and a ready flag is raised for it. A read strobe clears the flag and loads the word into a shift register, which then presents it bit by bit, most significant bit first. A supply-good input held low, a one-cycle general-call reset strobe and the ordinary reset all have the same effect.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A write on `cfg_we` stores `cfg_wdata`. Bits [1:0] are the resolution code (0, 1, 2, 3 select 12, 14, 16, 18 bits, and the output rate follows the resolution, code 0 being the 240 samples/s setting). Bits [3:2] are the gain code (0, 1, 2, 3 select 1, 2, 4, 8 V/V). Bit 4 is the mode (1 continuous, 0 one-shot). The stored codes appear on `mod_res` and `mod_gain` from the next conversion start.
- R2: Reset restores resolution code 0, gain code 0 and continuous mode, and clears `rdy`, `result`, `standby` and `mod_go`.
- R3: In one-shot mode, the completion of a conversion sets `standby` to 1 and issues no `mod_go`. The block stays in standby until `start` is seen. `mod_go` then pulses and `standby` falls in the next cycle.
- R4: After the end of reset, the first `mod_go` pulse is seen exactly SETTLE_CYC+1 clock cycles later, where SETTLE_CYC = CLK_MHZ*SETTLE_US. Nothing starts before then.
- R5: In continuous mode, `mod_go` pulses in the same cycle in which the finished result becomes visible, with no command.
- R6: A low `pwr_good` or a one-cycle `gc_reset` acts exactly as `rst_n` low. It restores the defaults, clears `rdy` and `result`, and restarts the full settling interval.
- R7: The low W bits of `mod_data` (W = 12 + 2 × resolution code) are a two's complement value. `result` is that value sign-extended to 18 bits and ignores the bits above W. For 12 bits, negative full scale 0x800 becomes 0x3F800, and positive full scale 0x7FF becomes 0x007FF.
- R8: `rdy` rises in the cycle after `mod_done` during a conversion. It stays high until `rd` or a reset. If `rd` and `mod_done` coincide, `rdy` stays high with the new result.
- R9: `rd` loads `result` into the output shifter, and `sdo` then shows bit 17. Each cycle with `shift` high moves the next lower bit onto `sdo`.
- R10: A configuration write made during a conversion does not change that conversion. `mod_res` and `mod_gain` change only in a cycle where `mod_go` pulses, and the result in progress is extended with the old resolution.
- R11: `start` outside standby, and `mod_done` outside a conversion, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply-good flag; low holds the block in reset |
| gc_reset | input | 1 | General-call reset strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 5 | Configuration word {mode, gain code, resolution code} |
| start | input | 1 | One-shot conversion command |
| mod_done | input | 1 | Modulator conversion finished |
| mod_data | input | 18 | Modulator raw result, right-aligned |
| rd | input | 1 | Result read strobe |
| shift | input | 1 | Advance the output shifter by one bit |
| mod_go | output | 1 | One-cycle conversion start to the modulator |
| mod_res | output | 2 | Resolution code of the current conversion |
| mod_gain | output | 2 | Gain code of the current conversion |
| standby | output | 1 | Low-power standby indicator |
| rdy | output | 1 | Result ready |
| result | output | 18 | Sign-extended result word |
| sdo | output | 1 | Serial result bit, MSB first |

## Verification
The hardest case to reach is a configuration change that lands while a conversion is in flight. The old resolution must still govern the result being finished, and the new one must appear only on the following start. The bench reaches it by writing each new resolution right after a `mod_go` pulse. It then checks that the result completing next is extended at the old width, and that the following `mod_go` carries the new codes. This chains through all four resolutions with full-scale, zero and mixed patterns that have garbage above the active width. A general-call reset is likewise fired in the middle of a conversion with a non-default configuration, so that the return to the defaults and the restart of settling can be seen.

// File: rtl/adc_seq_pkg.sv
// Shared types and helpers for the conversion sequencer.
// Assumes resolutions are BASE_W + STEP_W*code bits, the widest being DATA_W.
package adc_seq_pkg;

    localparam int DATA_W = 18;
    localparam int BASE_W = 12;
    localparam int STEP_W = 2;
    localparam int CFG_W  = 5;

    // Configuration word: mode, gain code, resolution code
    typedef struct packed {
        logic       cont;
        logic [1:0] gain;
        logic [1:0] res;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{cont: 1'b1, gain: 2'd0, res: 2'd0};

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_CONV   = 2'd1,
        ST_STBY   = 2'd2
    } seq_st_t;

    // Sign-extend the low (BASE_W + STEP_W*code) bits of raw to DATA_W bits
    function automatic logic [DATA_W-1:0] sign_fill(input logic [DATA_W-1:0] raw,
                                                   input logic [1:0] code);
        int w;
        logic [DATA_W-1:0] o;
        w = BASE_W + STEP_W * int'(code);
        for (int i = 0; i < DATA_W; i++) begin
            o[i] = (i < w) ? raw[i] : raw[w-1];
        end
        return o;
    endfunction

endpackage

// File: rtl/adc_settle_timer.sv
// Settling timer: counts CYC cycles after reset, then holds done high.
// Assumes srst_n merges every reset source, so each one restarts the count.
module adc_settle_timer #(
    parameter int CYC = 30000
) (
    input  logic clk,
    input  logic srst_n,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CYC);

    logic [CW-1:0] cnt;

    // Saturating up-counter from reset
    always_ff @(posedge clk) begin
        if (!srst_n)
            cnt <= '0;
        else if (cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIMIT);

    // Once settled, stays settled until the next reset
    p_done_sticky_r4: assert property (@(posedge clk) disable iff (!srst_n)
        done |=> done);

endmodule

// File: rtl/adc_cfg_reg.sv
// Configuration register: holds the user configuration, restores the defaults on reset.
// Assumes the write word is already in the cfg_t layout.
module adc_cfg_reg
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic srst_n,
    input  logic we,
    input  cfg_t wdata,
    output cfg_t cfg
);
    // Store writes, default on reset
    always_ff @(posedge clk) begin
        if (!srst_n)
            cfg <= CFG_DEFAULT;
        else if (we)
            cfg <= wdata;
    end

endmodule

// File: rtl/adc_result_capture.sv
// Result capture: sign-extends the finished raw word and keeps the ready flag.
// Assumes code is the resolution of the conversion being captured.
module adc_result_capture
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              srst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] raw,
    input  logic [1:0]        code,
    input  logic              rd,
    output logic [DATA_W-1:0] result,
    output logic              rdy
);
    // Latch the extended word on capture
    always_ff @(posedge clk) begin
        if (!srst_n)
            result <= '0;
        else if (cap)
            result <= sign_fill(raw, code);
    end

    // Ready: set by capture (wins), cleared by read
    always_ff @(posedge clk) begin
        if (!srst_n)
            rdy <= 1'b0;
        else if (cap)
            rdy <= 1'b1;
        else if (rd)
            rdy <= 1'b0;
    end

    p_rdy_hold_r8: assert property (@(posedge clk) disable iff (!srst_n)
        rdy && !rd |=> rdy);
    p_rd_clear_r8: assert property (@(posedge clk) disable iff (!srst_n)
        rd && !cap |=> !rdy);
    p_cap_sets_r8: assert property (@(posedge clk) disable iff (!srst_n)
        cap |=> rdy);

endmodule

// File: rtl/adc_result_shifter.sv
// Output shifter: loads a result word and presents it MSB first on sdo.
// Assumes load has priority over shift in the same cycle.
module adc_result_shifter
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              srst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              shift,
    output logic              sdo
);
    logic [DATA_W-1:0] sh;

    // Load or shift toward the MSB
    always_ff @(posedge clk) begin
        if (!srst_n)
            sh <= '0;
        else if (load)
            sh <= din;
        else if (shift)
            sh <= {sh[DATA_W-2:0], 1'b0};
    end

    assign sdo = sh[DATA_W-1];

    p_shift_order_r9: assert property (@(posedge clk) disable iff (!srst_n)
        shift && !load |=> sdo == $past(sh[DATA_W-2]));

endmodule

// File: rtl/adc_seq_ctrl.sv
// Conversion sequencer top: merges the reset sources, waits out settling, then
// runs continuous or one-shot conversions and captures their sign-extended results.
// Assumes a single clock and that the modulator answers each mod_go with one mod_done.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int SETTLE_US = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              gc_reset,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              start,
    input  logic              mod_done,
    input  logic [DATA_W-1:0] mod_data,
    input  logic              rd,
    input  logic              shift,
    output logic              mod_go,
    output logic [1:0]        mod_res,
    output logic [1:0]        mod_gain,
    output logic              standby,
    output logic              rdy,
    output logic [DATA_W-1:0] result,
    output logic              sdo
);
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

    logic    srst_n;
    logic    settle_done;
    cfg_t    cfg;
    cfg_t    act_cfg;
    seq_st_t state;
    logic    conv_start;
    logic    cap;

    // All reset sources collapse into one synchronous reset
    assign srst_n = rst_n & pwr_good & ~gc_reset;

    adc_settle_timer #(.CYC(SETTLE_CYC)) i_timer (
        .clk    (clk),
        .srst_n (srst_n),
        .done   (settle_done)
    );

    adc_cfg_reg i_cfg (
        .clk    (clk),
        .srst_n (srst_n),
        .we     (cfg_we),
        .wdata  (cfg_t'(cfg_wdata)),
        .cfg    (cfg)
    );

    assign cap = (state == ST_CONV) && mod_done;

    // Decide whether a conversion starts at this edge
    always_comb begin
        conv_start = 1'b0;
        case (state)
            ST_SETTLE: conv_start = settle_done && cfg.cont;
            ST_CONV:   conv_start = mod_done && cfg.cont;
            ST_STBY:   conv_start = start;
            default:   conv_start = 1'b0;
        endcase
    end

    // Sequencer state, start pulse and per-conversion configuration
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            state   <= ST_SETTLE;
            mod_go  <= 1'b0;
            act_cfg <= CFG_DEFAULT;
        end else begin
            mod_go <= conv_start;
            if (conv_start) begin
                act_cfg <= cfg;
                state   <= ST_CONV;
            end else if ((state == ST_SETTLE && settle_done) || cap) begin
                state <= ST_STBY;
            end
        end
    end

    assign mod_res  = act_cfg.res;
    assign mod_gain = act_cfg.gain;
    assign standby  = (state == ST_STBY);

    adc_result_capture i_cap (
        .clk    (clk),
        .srst_n (srst_n),
        .cap    (cap),
        .raw    (mod_data),
        .code   (act_cfg.res),
        .rd     (rd),
        .result (result),
        .rdy    (rdy)
    );

    adc_result_shifter i_shift (
        .clk    (clk),
        .srst_n (srst_n),
        .load   (rd),
        .din    (result),
        .shift  (shift),
        .sdo    (sdo)
    );

    p_go_after_settle_r4: assert property (@(posedge clk) disable iff (!srst_n)
        mod_go |-> settle_done);
    p_standby_quiet_r3: assert property (@(posedge clk) disable iff (!srst_n)
        standby |-> !mod_go);
    p_standby_exit_r3: assert property (@(posedge clk) disable iff (!srst_n)
        standby && start |=> mod_go && !standby);
    p_codes_on_go_r10: assert property (@(posedge clk) disable iff (!srst_n)
        $past(srst_n) && !($stable(mod_res) && $stable(mod_gain)) |-> mod_go);

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
    localparam int SETTLE_US = 1;
    localparam int N = 100 * SETTLE_US;

    logic        clk = 1'b0;
    logic        rst_n, pwr_good, gc_reset, cfg_we, start, mod_done, rd, shift;
    logic [4:0]  cfg_wdata;
    logic [17:0] mod_data;
    logic        mod_go, standby, rdy, sdo;
    logic [1:0]  mod_res, mod_gain;
    logic [17:0] result;

    int errors = 0;
    int checks = 0;
    bit rdy_exp = 1'b0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    adc_seq_ctrl #(.CLK_MHZ(100), .SETTLE_US(SETTLE_US)) i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .gc_reset(gc_reset),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .start(start),
        .mod_done(mod_done), .mod_data(mod_data), .rd(rd), .shift(shift),
        .mod_go(mod_go), .mod_res(mod_res), .mod_gain(mod_gain),
        .standby(standby), .rdy(rdy), .result(result), .sdo(sdo)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Expected sign-extended word, computed arithmetically
    function automatic logic [17:0] ext(input logic [17:0] d, input int code);
        int w;
        longint v;
        w = 12 + 2 * code;
        v = longint'(d) & ((longint'(1) << w) - 1);
        if (v >= (longint'(1) << (w - 1))) v = v - (longint'(1) << w);
        return 18'(v);
    endfunction

    // Test patterns: full scales, zero, -1, +1, then mixed words
    function automatic logic [17:0] pat(input int code, input int k);
        int w;
        longint m, v;
        w = 12 + 2 * code;
        m = (longint'(1) << w) - 1;
        case (k)
            0: v = longint'(1) << (w - 1);
            1: v = 0;
            2: v = (longint'(1) << (w - 1)) - 1;
            3: v = m;
            4: v = 1;
            default: v = (longint'(k) * 99_131 + 24_301) & 18'h3FFFF;
        endcase
        v = v | (longint'(18'h2AAAA) & ~m & 18'h3FFFF);
        return 18'(v);
    endfunction

    task automatic wait_go(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!mod_go && n < 5000);
    endtask

    // Complete the conversion in flight; expect the result at width code
    task automatic finish_conv(input logic [17:0] d, input int code, input bit cont);
        logic [17:0] e;
        repeat (2) tick();
        chk(rdy == rdy_exp, "R8 ready held until read", int'(rdy), int'(rdy_exp));
        mod_done = 1'b1;
        mod_data = d;
        tick();
        mod_done = 1'b0;
        mod_data = 18'h15555;
        e = ext(d, code);
        chk(result == e, "R7 sign extension", int'(result), int'(e));
        chk(rdy == 1'b1, "R8 ready after done", int'(rdy), 1);
        if (cont)
            chk(mod_go == 1'b1 && standby == 1'b0, "R5 continuous restart", int'(mod_go), 1);
        else
            chk(mod_go == 1'b0 && standby == 1'b1, "R3 one-shot standby", int'(standby), 1);
        rdy_exp = 1'b1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        int n, m, cur;
        logic [17:0] e;
        rst_n = 1'b0; pwr_good = 1'b1; gc_reset = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        start = 1'b0; mod_done = 1'b0; mod_data = '0; rd = 1'b0; shift = 1'b0;
        repeat (4) tick();
        chk(rdy == 0 && result == 0, "R2 reset outputs", int'(result), 0);
        chk(standby == 0 && mod_go == 0, "R2 reset control", int'(standby), 0);

        // Settling, with a start strobe thrown in (R11)
        rst_n = 1'b1;
        n = 0;
        repeat (3) begin tick(); n++; end
        start = 1'b1; tick(); n++; start = 1'b0;
        chk(standby == 0 && mod_go == 0, "R11 start ignored while settling", int'(mod_go), 0);
        wait_go(m);
        chk(n + m == N + 1, "R4 settle delay", n + m, N + 1);
        chk(mod_res == 0 && mod_gain == 0, "R2 default codes", int'({mod_gain, mod_res}), 0);

        // Sweep all resolutions, changing config mid-conversion (R10, R1)
        cur = 0;
        for (int code = 0; code < 4; code++) begin
            cfg_we = 1'b1; cfg_wdata = {1'b1, 2'(code), 2'(code)}; tick(); cfg_we = 1'b0;
            chk(mod_res == 2'(cur), "R10 write waits for next start", int'(mod_res), cur);
            finish_conv(pat(code, 7 + code), cur, 1'b1);
            chk(mod_res == 2'(code) && mod_gain == 2'(code), "R1 codes on next start",
                int'({mod_gain, mod_res}), code * 5);
            cur = code;
            for (int k = 0; k < 12; k++) finish_conv(pat(code, k), code, 1'b1);
        end

        // Read and serial output (R8, R9)
        e = ext(pat(3, 11), 3);
        rd = 1'b1; tick(); rd = 1'b0; rdy_exp = 1'b0;
        chk(rdy == 0, "R8 read clears ready", int'(rdy), 0);
        chk(sdo == e[17], "R9 first serial bit", int'(sdo), int'(e[17]));
        shift = 1'b1;
        for (int i = 16; i >= 0; i--) begin
            tick();
            chk(sdo == e[i], "R9 serial bit order", int'(sdo), int'(e[i]));
        end
        shift = 1'b0;

        // Read coinciding with done (R8)
        repeat (2) tick();
        mod_done = 1'b1; mod_data = pat(3, 0); rd = 1'b1; tick();
        mod_done = 1'b0; rd = 1'b0;
        chk(rdy == 1 && result == ext(pat(3, 0), 3), "R8 done beats read", int'(result),
            int'(ext(pat(3, 0), 3)));
        rdy_exp = 1'b1;

        // One-shot mode (R3)
        cfg_we = 1'b1; cfg_wdata = {1'b0, 2'd1, 2'd2}; tick(); cfg_we = 1'b0;
        finish_conv(pat(3, 5), 3, 1'b0);
        n = 0;
        repeat (20) begin tick(); if (mod_go || !standby) n++; end
        chk(n == 0, "R3 stays in standby", n, 0);
        mod_done = 1'b1; mod_data = 18'h00123; tick(); mod_done = 1'b0;
        chk(result == ext(pat(3, 5), 3), "R11 done outside conversion ignored", int'(result),
            int'(ext(pat(3, 5), 3)));
        start = 1'b1; tick(); start = 1'b0;
        chk(mod_go == 1 && standby == 0, "R3 start leaves standby", int'(mod_go), 1);
        chk(mod_res == 2 && mod_gain == 1, "R1 one-shot codes", int'({mod_gain, mod_res}), 6);
        start = 1'b1; tick(); start = 1'b0;
        finish_conv(pat(2, 6), 2, 1'b0);
        n = 0;
        repeat (5) begin tick(); if (mod_go) n++; end
        chk(n == 0, "R11 start during conversion ignored", n, 0);

        // General-call reset mid-conversion (R6)
        cfg_we = 1'b1; cfg_wdata = {1'b1, 2'd3, 2'd3}; tick(); cfg_we = 1'b0;
        start = 1'b1; tick(); start = 1'b0;
        chk(mod_res == 3, "R1 non-default before reset", int'(mod_res), 3);
        tick();
        gc_reset = 1'b1; tick(); gc_reset = 1'b0;
        chk(rdy == 0 && result == 0 && standby == 0, "R6 general-call clears", int'(result), 0);
        rdy_exp = 1'b0;
        wait_go(m);
        chk(m == N + 1, "R6 general-call restarts settling", m, N + 1);
        chk(mod_res == 0 && mod_gain == 0, "R6 defaults restored", int'({mod_gain, mod_res}), 0);
        finish_conv(pat(0, 3), 0, 1'b1);

        // Supply-good low (R6)
        pwr_good = 1'b0;
        n = 0;
        repeat (10) begin tick(); if (mod_go || rdy || standby) n++; end
        chk(n == 0, "R6 held in reset while supply low", n, 0);
        rdy_exp = 1'b0;
        pwr_good = 1'b1;
        wait_go(m);
        chk(m == N + 1, "R6 supply restart settling", m, N + 1);
        finish_conv(pat(0, 0), 0, 1'b1);

        done_flag = 1'b1;
        summary();
    end
endmodule